// File: doc/BRIEF.md
# Load-Driven Frequency/Voltage Governor

This block chooses a performance level for a processor from a periodic load sample and then drives that level into the regulator and the clock generator in a safe order. A measurement unit elsewhere supplies an 8-bit load percentage together with a one-cycle sample strobe. Five policies are available. Two of them react to load using different thresholds and step sizes. Two of them pin the level at one end of the range. The fifth follows a target written by software. A lid-close input overrides every policy and drives the level to the floor.

Every level change is a handshake with two slow external units. When the level rises, the voltage request moves first and the block waits for a settle acknowledge before it moves the frequency request. It then waits for the clock-lock acknowledge before it commits the new level. When the level falls, the order is reversed: frequency goes first and waits for lock, then voltage goes and waits for settle. While a change is in flight the block reports busy, and it discards any load sample that arrives during that time.

Top module: `dvfs_governor`

## Requirements
- R1: After reset, level_o, volt_req_o and freq_req_o are all 0 and busy_o is low.
- R2: Policy code 0 (ondemand): a load of 95 or more targets the top level (NUM_LEVELS-1). A load below 30 targets one level lower. A load from 30 to 94 keeps the current level.
- R3: Policy code 1 (conservative): a load of 75 or more targets one level higher. A load below 20 targets one level lower. A load from 20 to 74 keeps the current level.
- R4: Policy code 2 targets the top level and policy code 3 targets level 0, whatever the load. Codes 5 to 7 keep the current level.
- R5: Policy code 4 (userspace) targets user_level_i, clamped to the top level.
- R6: On a raise, volt_req_o takes the target first while freq_req_o and level_o keep the old value. freq_req_o follows one cycle after volt_settled_i is sampled high. level_o takes the target one cycle after pll_locked_i is sampled high.
- R7: On a lowering, freq_req_o takes the target first while volt_req_o keeps the old value. volt_req_o follows one cycle after pll_locked_i is sampled high. level_o commits one cycle after volt_settled_i is sampled high.
- R8: Decisions are taken only on a cycle with sample_tick_i high while the block is idle. A tick that arrives while busy_o is high has no effect on the transition in flight or on its final level.
- R9: The level saturates at both ends. A step up at the top level and a step down at level 0 leave the level unchanged and start no transition.
- R10: While the block is idle, lid_close_i high starts a move to level 0 on the next cycle without waiting for a tick and whatever the policy. While lid_close_i stays high, ticks keep the level at 0.
- R11: busy_o rises in the cycle after a decision that changes the level and falls in the same cycle that level_o commits. While idle, volt_req_o and freq_req_o equal level_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_tick_i | input | 1 | One-cycle strobe marking a valid load sample |
| load_i | input | 8 | Load percentage |
| policy_i | input | 3 | Policy code (0 ondemand, 1 conservative, 2 performance, 3 powersave, 4 userspace) |
| user_level_i | input | $clog2(NUM_LEVELS) | Software-written target level for userspace |
| lid_close_i | input | 1 | Forces level 0 while high |
| volt_settled_i | input | 1 | Regulator acknowledge that the requested voltage is stable |
| pll_locked_i | input | 1 | Clock generator acknowledge that the requested frequency is locked |
| volt_req_o | output | $clog2(NUM_LEVELS) | Voltage level request |
| freq_req_o | output | $clog2(NUM_LEVELS) | Frequency level request |
| busy_o | output | 1 | A level transition is in progress |
| level_o | output | $clog2(NUM_LEVELS) | Committed performance level |

## Verification
The hardest case to reach is a load sample that arrives in the middle of a transition. The bench has to hold the handshake open on purpose to create it. To do so it starts a lowering and, before returning any lock acknowledge, issues a second tick whose userspace target points the other way. It then checks that both requests keep the first target through to the commit. The lid override is tested the same way, from a non-zero level with no tick present, and then again with ticks under the performance policy while the lid stays closed.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  typedef enum logic [2:0] {
    POL_ONDEMAND = 3'd0,
    POL_CONSERV  = 3'd1,
    POL_PERF     = 3'd2,
    POL_SAVE     = 3'd3,
    POL_USER     = 3'd4
  } policy_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UP_VOLT,
    SQ_UP_FREQ,
    SQ_DN_FREQ,
    SQ_DN_VOLT
  } seq_state_e;

endpackage

// File: rtl/dvfs_policy.sv
module dvfs_policy
  import dvfs_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int OD_UP_PCT  = 95,
  parameter int OD_DN_PCT  = 30,
  parameter int CS_UP_PCT  = 75,
  parameter int CS_DN_PCT  = 20,
  localparam int LW = $clog2(NUM_LEVELS)
) (
  input  logic [7:0]    load_i,
  input  logic [2:0]    policy_i,
  input  logic [LW-1:0] cur_level_i,
  input  logic [LW-1:0] user_level_i,
  output logic [LW-1:0] target_o
);

  localparam logic [LW-1:0] MAX_LVL = LW'(NUM_LEVELS - 1);
  localparam logic [7:0] OD_UP = 8'(OD_UP_PCT);
  localparam logic [7:0] OD_DN = 8'(OD_DN_PCT);
  localparam logic [7:0] CS_UP = 8'(CS_UP_PCT);
  localparam logic [7:0] CS_DN = 8'(CS_DN_PCT);

  logic [LW-1:0] step_up, step_dn, user_clamped;

  // saturating single steps
  assign step_up = (cur_level_i == MAX_LVL) ? MAX_LVL : cur_level_i + LW'(1);
  assign step_dn = (cur_level_i == '0) ? '0 : cur_level_i - LW'(1);

  generate
    if ((1 << LW) == NUM_LEVELS) begin : g_user_full
      assign user_clamped = user_level_i;
    end else begin : g_user_clamp
      assign user_clamped = (user_level_i > MAX_LVL) ? MAX_LVL : user_level_i;
    end
  endgenerate

  always_comb begin
    target_o = cur_level_i;
    case (policy_i)
      POL_ONDEMAND: begin
        if (load_i >= OD_UP)     target_o = MAX_LVL;
        else if (load_i < OD_DN) target_o = step_dn;
      end
      POL_CONSERV: begin
        if (load_i >= CS_UP)     target_o = step_up;
        else if (load_i < CS_DN) target_o = step_dn;
      end
      POL_PERF: target_o = MAX_LVL;
      POL_SAVE: target_o = '0;
      POL_USER: target_o = user_clamped;
      default:  target_o = cur_level_i;
    endcase
  end

endmodule

// File: rtl/dvfs_sequencer.sv
module dvfs_sequencer
  import dvfs_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  localparam int LW = $clog2(NUM_LEVELS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] target_i,
  input  logic          volt_settled_i,
  input  logic          pll_locked_i,
  output logic [LW-1:0] volt_req_o,
  output logic [LW-1:0] freq_req_o,
  output logic [LW-1:0] level_o,
  output logic          busy_o
);

  seq_state_e    state_q;
  logic [LW-1:0] tgt_q;

  assign busy_o = (state_q != SQ_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SQ_IDLE;
      tgt_q      <= '0;
      volt_req_o <= '0;
      freq_req_o <= '0;
      level_o    <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (start_i && target_i != level_o) begin
            tgt_q <= target_i;
            if (target_i > level_o) begin
              volt_req_o <= target_i;   // voltage leads on the way up
              state_q    <= SQ_UP_VOLT;
            end else begin
              freq_req_o <= target_i;   // frequency leads on the way down
              state_q    <= SQ_DN_FREQ;
            end
          end
        end
        SQ_UP_VOLT: if (volt_settled_i) begin
          freq_req_o <= tgt_q;
          state_q    <= SQ_UP_FREQ;
        end
        SQ_UP_FREQ: if (pll_locked_i) begin
          level_o <= tgt_q;
          state_q <= SQ_IDLE;
        end
        SQ_DN_FREQ: if (pll_locked_i) begin
          volt_req_o <= tgt_q;
          state_q    <= SQ_DN_VOLT;
        end
        SQ_DN_VOLT: if (volt_settled_i) begin
          level_o <= tgt_q;
          state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dvfs_governor.sv
module dvfs_governor
  import dvfs_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int OD_UP_PCT  = 95,
  parameter int OD_DN_PCT  = 30,
  parameter int CS_UP_PCT  = 75,
  parameter int CS_DN_PCT  = 20,
  localparam int LW = $clog2(NUM_LEVELS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_tick_i,
  input  logic [7:0]    load_i,
  input  logic [2:0]    policy_i,
  input  logic [LW-1:0] user_level_i,
  input  logic          lid_close_i,
  input  logic          volt_settled_i,
  input  logic          pll_locked_i,
  output logic [LW-1:0] volt_req_o,
  output logic [LW-1:0] freq_req_o,
  output logic          busy_o,
  output logic [LW-1:0] level_o
);

  logic [LW-1:0] policy_tgt, final_tgt;
  logic          start;

  dvfs_policy #(
    .NUM_LEVELS(NUM_LEVELS),
    .OD_UP_PCT (OD_UP_PCT),
    .OD_DN_PCT (OD_DN_PCT),
    .CS_UP_PCT (CS_UP_PCT),
    .CS_DN_PCT (CS_DN_PCT)
  ) u_policy (
    .load_i      (load_i),
    .policy_i    (policy_i),
    .cur_level_i (level_o),
    .user_level_i(user_level_i),
    .target_o    (policy_tgt)
  );

  // lid override wins over any policy and needs no tick
  assign final_tgt = lid_close_i ? '0 : policy_tgt;
  assign start     = (sample_tick_i || lid_close_i) && !busy_o;

  dvfs_sequencer #(
    .NUM_LEVELS(NUM_LEVELS)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .target_i      (final_tgt),
    .volt_settled_i(volt_settled_i),
    .pll_locked_i  (pll_locked_i),
    .volt_req_o    (volt_req_o),
    .freq_req_o    (freq_req_o),
    .level_o       (level_o),
    .busy_o        (busy_o)
  );

endmodule

// File: rtl/dvfs_governor_chk.sv
module dvfs_governor_chk #(
  parameter int NUM_LEVELS = 8,
  localparam int LW = $clog2(NUM_LEVELS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sample_tick_i,
  input logic          lid_close_i,
  input logic          volt_settled_i,
  input logic          pll_locked_i,
  input logic [LW-1:0] volt_req_o,
  input logic [LW-1:0] freq_req_o,
  input logic          busy_o,
  input logic [LW-1:0] level_o
);

  localparam logic [LW-1:0] MAX_LVL = LW'(NUM_LEVELS - 1);

  AST_FREQ_NOT_ABOVE_VOLT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_req_o <= volt_req_o); // R6 R7

  AST_FREQ_RISE_AFTER_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_req_o > $past(freq_req_o)) |-> $past(volt_settled_i)); // R6

  AST_VOLT_DROP_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (volt_req_o < $past(volt_req_o)) |-> $past(pll_locked_i)); // R7

  AST_NO_START_WITHOUT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(sample_tick_i || lid_close_i)); // R8

  AST_LEVEL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= MAX_LVL); // R9

  AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != $past(level_o)) |-> $fell(busy_o)); // R11

  AST_IDLE_REQS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (volt_req_o == level_o && freq_req_o == level_o)); // R11

endmodule

bind dvfs_governor dvfs_governor_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sample_tick_i (sample_tick_i),
  .lid_close_i   (lid_close_i),
  .volt_settled_i(volt_settled_i),
  .pll_locked_i  (pll_locked_i),
  .volt_req_o    (volt_req_o),
  .freq_req_o    (freq_req_o),
  .busy_o        (busy_o),
  .level_o       (level_o)
);

// File: tb/dvfs_governor_test.sv
module dvfs_governor_test;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int LW = $clog2(NL);
  localparam int TOP = NL - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sample_tick_i = 1'b0;
  logic [7:0]    load_i = '0;
  logic [2:0]    policy_i = '0;
  logic [LW-1:0] user_level_i = '0;
  logic          lid_close_i = 1'b0;
  logic          volt_settled_i = 1'b0;
  logic          pll_locked_i = 1'b0;
  logic [LW-1:0] volt_req_o, freq_req_o, level_o;
  logic          busy_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dvfs_governor #(.NUM_LEVELS(NL)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_tick_i(sample_tick_i),
    .load_i(load_i), .policy_i(policy_i), .user_level_i(user_level_i),
    .lid_close_i(lid_close_i), .volt_settled_i(volt_settled_i),
    .pll_locked_i(pll_locked_i), .volt_req_o(volt_req_o),
    .freq_req_o(freq_req_o), .busy_o(busy_o), .level_o(level_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_volt();
    volt_settled_i = 1'b1;
    @(negedge clk_i);
    volt_settled_i = 1'b0;
  endtask

  task automatic pulse_pll();
    pll_locked_i = 1'b1;
    @(negedge clk_i);
    pll_locked_i = 1'b0;
  endtask

  // walk a started transition to completion, checking order at each step
  task automatic finish_move(input string req, input int old, input int exp);
    if (exp > old) begin
      check("R6", "up volt first", volt_req_o, exp);
      check("R6", "up freq held", freq_req_o, old);
      check("R11", "busy during up", busy_o, 1);
      pulse_volt();
      check("R6", "up freq after settle", freq_req_o, exp);
      check("R6", "up level not yet", level_o, old);
      pulse_pll();
    end else begin
      check("R7", "down freq first", freq_req_o, exp);
      check("R7", "down volt held", volt_req_o, old);
      check("R11", "busy during down", busy_o, 1);
      pulse_pll();
      check("R7", "down volt after lock", volt_req_o, exp);
      check("R7", "down level not yet", level_o, old);
      pulse_volt();
    end
    check(req, "level commit", level_o, exp);
    check("R11", "busy cleared", busy_o, 0);
  endtask

  task automatic step(input string req, input int ld, input int pol, input int usr, input int exp);
    int old;
    old = level_o;
    load_i = 8'(ld); policy_i = 3'(pol); user_level_i = LW'(usr);
    sample_tick_i = 1'b1;
    @(negedge clk_i);
    sample_tick_i = 1'b0;
    if (exp == old) begin
      check(req, "hold level", level_o, exp);
      check(req, "no transition", busy_o, 0);
    end else begin
      finish_move(req, old, exp);
    end
  endtask

  task automatic t_reset();
    check("R1", "reset level", level_o, 0);
    check("R1", "reset volt", volt_req_o, 0);
    check("R1", "reset freq", freq_req_o, 0);
    check("R1", "reset busy", busy_o, 0);
  endtask

  task automatic t_ondemand();
    step("R2", 95, 0, 0, TOP);
    step("R2", 50, 0, 0, TOP);
    step("R2", 29, 0, 0, TOP - 1);
    step("R2", 94, 0, 0, TOP - 1);
    step("R2", 30, 0, 0, TOP - 1);
  endtask

  task automatic t_conservative();
    step("R3", 75, 1, 0, TOP);
    step("R9", 100, 1, 0, TOP);
    step("R3", 20, 1, 0, TOP);
    step("R3", 19, 1, 0, TOP - 1);
    step("R3", 74, 1, 0, TOP - 1);
  endtask

  task automatic t_fixed();
    step("R4", 100, 3, 0, 0);
    step("R9", 0, 0, 0, 0);
    step("R9", 5, 1, 0, 0);
    step("R4", 0, 2, 0, TOP);
    step("R4", 0, 6, 0, TOP);
  endtask

  task automatic t_user();
    step("R5", 0, 4, 3, 3);
    step("R5", 99, 4, 5, 5);
  endtask

  task automatic t_busy_ignore();
    // no tick: nothing moves
    policy_i = 3'd0; load_i = 8'd100;
    repeat (4) @(negedge clk_i);
    check("R8", "no tick no change", level_o, 5);
    check("R8", "no tick idle", busy_o, 0);
    // start a lowering to 2, then tick for 7 mid-flight
    policy_i = 3'd4; user_level_i = LW'(2);
    sample_tick_i = 1'b1;
    @(negedge clk_i);
    user_level_i = LW'(7);
    @(negedge clk_i);
    sample_tick_i = 1'b0;
    check("R8", "freq keeps first target", freq_req_o, 2);
    check("R8", "volt untouched", volt_req_o, 5);
    finish_move("R8", 5, 2);
  endtask

  task automatic t_lid();
    policy_i = 3'd2; load_i = 8'd100;
    lid_close_i = 1'b1;
    @(negedge clk_i);
    check("R10", "lid starts move", busy_o, 1);
    finish_move("R10", 2, 0);
    step("R10", 100, 2, 0, 0);
    lid_close_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ondemand();
    t_conservative();
    t_fixed();
    t_user();
    t_busy_ignore();
    t_lid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule